// File: doc/BRIEF.md
# Iterative Radix-2 FFT Core

This block computes an N-point complex discrete Fourier transform, N = 2^LOG2N (1024 by default), with one butterfly datapath and one sample store that is overwritten in place. Samples are written in one at a time while the core is idle. The writer supplies them in bit-reversed index order. A start pulse then launches LOG2N passes of N/2 butterflies each, at one butterfly per clock. Each butterfly reads a pair from the store, multiplies the lower element by a Q15 twiddle, and writes back the sum and the difference.

Each sum and difference is halved in that same write. This keeps the word width constant across stages, and no cycle is spent on a separate scaling step. Twiddle addresses come from a shift of the butterfly's position inside its group, so no multiplier is needed to form them. A parameter selects the twiddle table: a full half-period table, or a quarter-period cosine table with folding logic. When every pass has finished, a one-cycle done flag is raised and the N results stream out in natural order under a valid strobe.

Top module: `fft_iter_core`

## Requirements
- R1: After synchronous reset, done and out_valid are low.
- R2: While idle, each cycle with in_valid high stores (in_re, in_im) at the next store position, starting from position 0 after reset and after each accepted start. The writer places input sample x[n] at position bitrev(n), the LOG2N-bit index reversed.
- R3: Pass s applies this butterfly to the pair (a at top, b at bottom). With W = cos - j*sin of 2*pi*k/N, take t_re = (c*b_re + s*b_im + 2^14) >>> 15 and t_im = (c*b_im - s*b_re + 2^14) >>> 15. Here c and s are 32767*cos and 32767*sin of 2*pi*k/N, each rounded half away from zero. The top result is (a + t) >>> 1 and the bottom result is (a - t) >>> 1, each kept to its low 16 bits. Samples and twiddles are 16-bit signed.
- R4: In pass s, butterfly b has idx = b mod 2^s. Its top position is 2^(s+1)*floor(b/2^s) + idx, its bottom position is the top position plus 2^s, and its twiddle index is k = idx << (LOG2N-1-s).
- R5: When start is sampled high at an idle rising edge E, done is high exactly in the cycle after edge E + LOG2N*N/2. This is one edge per butterfly, with no extra cycle per pass.
- R6: done is high for a single cycle per transform.
- R7: In the N cycles right after done, out_valid is high and out_re/out_im carry bins 0, 1, ..., N-1 in order. out_valid is low after that.
- R8: A start pulse that arrives while a transform is running or its results are streaming has no effect. It does not change the done timing, and it launches no second transform.
- R9: in_valid is ignored outside the idle state. The store is not altered, so the results are unchanged.
- R10: The quarter-period twiddle table variant gives results identical to the full table variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe, honoured only while idle |
| in_re | input | 16 | Input sample, real part, signed |
| in_im | input | 16 | Input sample, imaginary part, signed |
| start | input | 1 | Launch the transform (honoured only while idle) |
| done | output | 1 | One-cycle flag after the last pass |
| out_valid | output | 1 | Result strobe |
| out_re | output | 16 | Result, real part, signed |
| out_im | output | 16 | Result, imaginary part, signed |

## Verification
Two events can land in the same cycle. A host may raise start, or drive in_valid, while butterflies are being written or results are being read out. The bench provokes both on purpose. It fires a second start in the middle of a pass and another during the result stream, and it drives junk samples with in_valid high on every cycle of a run. Each such run is judged by an exact done cycle count, by the absence of any second done or stream, and by a bin-for-bin match against an arithmetic model of the scaled butterfly.

// File: rtl/fft_pkg.sv
`timescale 1ns/1ps
package fft_pkg;

    localparam int SAMPLE_W = 16;
    localparam int FRAC_W   = SAMPLE_W - 1;
    localparam real TWO_PI  = 6.283185307179586;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] re;
        logic signed [SAMPLE_W-1:0] im;
    } cplx_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2,
        ST_OUT  = 2'd3
    } fft_state_t;

    // Scale a value in [-1,1] to Q15, rounding half away from zero.
    function automatic logic signed [SAMPLE_W-1:0] to_q15(real v);
        real scaled;
        int  r;
        scaled = v * 32767.0;
        if (scaled >= 0.0) r = $rtoi(scaled + 0.5);
        else               r = -$rtoi(-scaled + 0.5);
        return SAMPLE_W'(r);
    endfunction

    function automatic logic signed [SAMPLE_W-1:0] q15_cos(int k, int n);
        return to_q15($cos(TWO_PI * real'(k) / real'(n)));
    endfunction

    function automatic logic signed [SAMPLE_W-1:0] q15_sin(int k, int n);
        return to_q15($sin(TWO_PI * real'(k) / real'(n)));
    endfunction

    function automatic int bit_rev(int v, int w);
        int r;
        r = 0;
        for (int i = 0; i < w; i++) r = r | (((v >> i) & 1) << (w - 1 - i));
        return r;
    endfunction

endpackage

// File: rtl/fft_twiddle_rom.sv
`timescale 1ns/1ps
module fft_twiddle_rom
    import fft_pkg::*;
#(
    parameter int LOG2N   = 10,
    parameter bit QUARTER = 1'b0
) (
    input  logic [LOG2N-2:0] k,
    output cplx_t            w      // re = cos, im = +sin of 2*pi*k/N
);
    localparam int N  = 1 << LOG2N;
    localparam int KW = LOG2N - 1;
    localparam int Q  = N / 4;

    if (QUARTER) begin : g_quarter
        logic signed [SAMPLE_W-1:0] tab [0:Q];
        for (genvar i = 0; i <= Q; i++) begin : g_e
            localparam logic signed [SAMPLE_W-1:0] V = q15_cos(i, N);
            assign tab[i] = V;
        end

        logic [KW-1:0] m_ext;
        logic [KW-1:0] mirror;
        always_comb begin
            m_ext  = {1'b0, k[KW-2:0]};
            mirror = KW'(Q) - m_ext;
            if (!k[KW-1]) begin
                w.re = tab[m_ext];
                w.im = tab[mirror];
            end else begin
                w.re = -tab[mirror];
                w.im = tab[m_ext];
            end
        end
    end else begin : g_full
        logic signed [SAMPLE_W-1:0] ctab [0:N/2-1];
        logic signed [SAMPLE_W-1:0] stab [0:N/2-1];
        for (genvar i = 0; i < N/2; i++) begin : g_e
            localparam logic signed [SAMPLE_W-1:0] VC = q15_cos(i, N);
            localparam logic signed [SAMPLE_W-1:0] VS = q15_sin(i, N);
            assign ctab[i] = VC;
            assign stab[i] = VS;
        end
        always_comb begin
            w.re = ctab[k];
            w.im = stab[k];
        end
    end
endmodule

// File: rtl/fft_addr_gen.sv
`timescale 1ns/1ps
module fft_addr_gen #(
    parameter int LOG2N = 10,
    parameter int STW   = $clog2(LOG2N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [STW-1:0]   stage,
    output logic [LOG2N-1:0] top,
    output logic [LOG2N-1:0] bot,
    output logic [LOG2N-2:0] tw_k,
    output logic             last
);
    localparam int AW = LOG2N;
    localparam int KW = LOG2N - 1;

    logic [KW-1:0]  bfly_q;
    logic [STW-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bfly_q  <= '0;
            stage_q <= '0;
        end else if (step) begin
            bfly_q <= bfly_q + 1'b1;
            if (bfly_q == '1) stage_q <= stage_q + 1'b1;
        end
    end

    logic [AW-1:0] span;
    logic [AW-1:0] low_mask;
    logic [AW-1:0] idx;
    int unsigned   shamt;

    always_comb begin
        span     = AW'(1) << stage_q;
        low_mask = span - 1'b1;
        idx      = {1'b0, bfly_q} & low_mask;
        top      = (({1'b0, bfly_q} & ~low_mask) << 1) | idx;
        bot      = top | span;
        shamt    = KW - int'(stage_q);
        tw_k     = KW'(idx << shamt);
    end

    assign stage = stage_q;
    assign last  = (stage_q == STW'(LOG2N - 1)) && (bfly_q == '1);
endmodule

// File: rtl/fft_butterfly.sv
`timescale 1ns/1ps
module fft_butterfly
    import fft_pkg::*;
(
    input  cplx_t a,
    input  cplx_t b,
    input  cplx_t w,
    output cplx_t y_top,
    output cplx_t y_bot
);
    localparam int PW = 2 * SAMPLE_W + 1;
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (FRAC_W - 1);

    logic signed [PW-1:0]         acc_re, acc_im;
    logic signed [SAMPLE_W+1:0]   t_re, t_im;
    logic signed [SAMPLE_W+2:0]   sum_re, sum_im, dif_re, dif_im;

    always_comb begin
        // conj(w) * b, rounded back from Q15
        acc_re = w.re * b.re + w.im * b.im + RND;
        acc_im = w.re * b.im - w.im * b.re + RND;
        t_re   = acc_re[PW-1:FRAC_W];
        t_im   = acc_im[PW-1:FRAC_W];
        sum_re = a.re + t_re;
        sum_im = a.im + t_im;
        dif_re = a.re - t_re;
        dif_im = a.im - t_im;
        // halving is a bit-select: drop bit 0, keep the next SAMPLE_W bits
        y_top.re = sum_re[SAMPLE_W:1];
        y_top.im = sum_im[SAMPLE_W:1];
        y_bot.re = dif_re[SAMPLE_W:1];
        y_bot.im = dif_im[SAMPLE_W:1];
    end
endmodule

// File: rtl/fft_iter_core.sv
`timescale 1ns/1ps
module fft_iter_core
    import fft_pkg::*;
#(
    parameter int LOG2N      = 10,
    parameter bit TW_QUARTER = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_re,
    input  logic signed [SAMPLE_W-1:0] in_im,
    input  logic                       start,
    output logic                       done,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_re,
    output logic signed [SAMPLE_W-1:0] out_im
);
    localparam int N   = 1 << LOG2N;
    localparam int AW  = LOG2N;
    localparam int KW  = LOG2N - 1;
    localparam int STW = $clog2(LOG2N);

    fft_state_t    st_q;
    logic [AW-1:0] ld_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    cplx_t         mem [0:N-1];

    logic           running;
    logic           last;
    logic [STW-1:0] stage;
    logic [AW-1:0]  top, bot;
    logic [KW-1:0]  tw_k;
    cplx_t          w, a, b, y_top, y_bot, rd_word;

    assign running = (st_q == ST_RUN);

    fft_addr_gen #(.LOG2N(LOG2N), .STW(STW)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .clear (!running),
        .step  (running),
        .stage (stage),
        .top   (top),
        .bot   (bot),
        .tw_k  (tw_k),
        .last  (last)
    );

    fft_twiddle_rom #(.LOG2N(LOG2N), .QUARTER(TW_QUARTER)) u_rom (
        .k (tw_k),
        .w (w)
    );

    assign a = mem[top];
    assign b = mem[bot];

    fft_butterfly u_bfly (
        .a     (a),
        .b     (b),
        .w     (w),
        .y_top (y_top),
        .y_bot (y_bot)
    );

    always_ff @(posedge clk) begin
        if (running) begin
            mem[top] <= y_top;
            mem[bot] <= y_bot;
        end else if (st_q == ST_IDLE && in_valid) begin
            mem[ld_ptr_q] <= '{re: in_re, im: in_im};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ld_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (in_valid) ld_ptr_q <= ld_ptr_q + 1'b1;
                    if (start) begin
                        st_q     <= ST_RUN;
                        ld_ptr_q <= '0;
                    end
                end
                ST_RUN: if (last) st_q <= ST_FIN;
                ST_FIN: begin
                    st_q     <= ST_OUT;
                    rd_ptr_q <= '0;
                end
                ST_OUT: begin
                    rd_ptr_q <= rd_ptr_q + 1'b1;
                    if (rd_ptr_q == '1) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_word   = mem[rd_ptr_q];
    assign done      = (st_q == ST_FIN);
    assign out_valid = (st_q == ST_OUT);
    assign out_re    = rd_word.re;
    assign out_im    = rd_word.im;
endmodule

// File: rtl/fft_iter_core_chk.sv
`timescale 1ns/1ps
module fft_iter_core_chk #(
    parameter int LOG2N = 10,
    parameter int STW   = $clog2(LOG2N),
    parameter int KW    = LOG2N - 1
) (
    input logic           clk,
    input logic           rst,
    input logic           done,
    input logic           out_valid,
    input logic           running,
    input logic [STW-1:0] stage,
    input logic [KW-1:0]  tw_k
);
    localparam int N    = 1 << LOG2N;
    localparam int CYC  = LOG2N * (N / 2);
    localparam int CW   = $clog2(CYC + 1) + 1;
    localparam int OW   = LOG2N + 2;

    logic [CW-1:0] run_cnt;
    logic [OW-1:0] out_cnt;
    logic [KW-1:0] stride_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            out_cnt <= '0;
        end else begin
            if (running)        run_cnt <= run_cnt + 1'b1;
            else if (out_valid) run_cnt <= '0;
            if (out_valid) out_cnt <= out_cnt + 1'b1;
            else           out_cnt <= '0;
        end
    end

    always_comb stride_mask = KW'((64'd1 << (KW - int'(stage))) - 64'd1);

    AST_RUN_CYCLES: assert property (@(posedge clk) disable iff (rst)
        done |-> run_cnt == CW'(CYC)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_STREAM_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        done |=> out_valid); // R7
    AST_STREAM_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> out_cnt == OW'(N)); // R7
    AST_QUIET_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        running |-> !out_valid && !done); // R8
    AST_TW_STRIDE: assert property (@(posedge clk) disable iff (rst)
        running |-> (tw_k & stride_mask) == '0); // R4
    AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (rst)
        running |-> int'(stage) < LOG2N); // R4
endmodule

bind fft_iter_core fft_iter_core_chk #(.LOG2N(LOG2N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .out_valid (out_valid),
    .running   (running),
    .stage     (stage),
    .tw_k      (tw_k)
);

// File: tb/tb_fft_iter_core.sv
`timescale 1ns/1ps
module tb_fft_iter_core;
    import fft_pkg::*;

    localparam int L = 3;
    localparam int N = 1 << L;
    localparam int M = L * N / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic start = 1'b0;
    logic signed [15:0] in_re = '0;
    logic signed [15:0] in_im = '0;
    logic done, out_valid, done_q, out_valid_q;
    logic signed [15:0] out_re, out_im, out_re_q, out_im_q;

    always #10 clk = ~clk;

    fft_iter_core #(.LOG2N(L), .TW_QUARTER(1'b0)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .start(start), .done(done), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    fft_iter_core #(.LOG2N(L), .TW_QUARTER(1'b1)) dut_q (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .start(start), .done(done_q), .out_valid(out_valid_q), .out_re(out_re_q), .out_im(out_im_q)
    );

    int checks = 0;
    int fails  = 0;
    longint xr[N], xi[N], er[N], ei[N], gr[N], gi[N], qr[N], qi[N];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint wrap16(longint v);
        logic signed [15:0] t;
        t = v[15:0];
        return longint'(t);
    endfunction

    // Arithmetic model of the scaled transform (R3, R4)
    task automatic ref_model();
        longint ar[N], ai[N];
        for (int p = 0; p < N; p++) begin
            ar[p] = xr[bit_rev(p, L)];
            ai[p] = xi[bit_rev(p, L)];
        end
        for (int s = 0; s < L; s++) begin
            for (int b = 0; b < N / 2; b++) begin
                int mask, idx, tp, bt, k;
                longint wc, ws, tr, ti, atr, ati;
                mask = (1 << s) - 1;
                idx  = b & mask;
                tp   = ((b & ~mask) << 1) | idx;
                bt   = tp + (1 << s);
                k    = idx << (L - 1 - s);
                wc   = longint'(q15_cos(k, N));
                ws   = longint'(q15_sin(k, N));
                tr   = (wc * ar[bt] + ws * ai[bt] + 16384) >>> 15;
                ti   = (wc * ai[bt] - ws * ar[bt] + 16384) >>> 15;
                atr  = ar[tp];
                ati  = ai[tp];
                ar[tp] = wrap16((atr + tr) >>> 1);
                ai[tp] = wrap16((ati + ti) >>> 1);
                ar[bt] = wrap16((atr - tr) >>> 1);
                ai[bt] = wrap16((ati - ti) >>> 1);
            end
        end
        for (int p = 0; p < N; p++) begin
            er[p] = ar[p];
            ei[p] = ai[p];
        end
    endtask

    // R2: sample x[n] goes to store position bitrev(n)
    task automatic load_vec();
        for (int p = 0; p < N; p++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re = 16'(xr[bit_rev(p, L)]);
            in_im = 16'(xi[bit_rev(p, L)]);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // mode 0 plain, 1 restart mid-run, 2 junk loads during run, 3 start during stream
    task automatic run_vec(string req, int mode);
        int cnt;
        bit seen, bad;
        ref_model();
        load_vec();
        start = 1'b1;
        cnt = 0;
        seen = 1'b0;
        while (!seen && cnt < M + 20) begin
            @(negedge clk);
            cnt++;
            if (done) seen = 1'b1;
            start = (mode == 1 && (cnt == 4 || cnt == M - 1));
            in_valid = (mode == 2) && !seen;
            in_re = 16'(cnt * 1234 - 7000);
            in_im = 16'(-cnt * 321);
        end
        in_valid = 1'b0;
        start = 1'b0;
        chk(seen && cnt == M + 1, (mode == 1) ? "R8" : "R5", "done cycle", cnt, M + 1);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            if (i == 0) chk(!done, "R6", "done width", done, 0);
            chk(out_valid && out_valid_q, "R7", "out_valid in stream", out_valid, 1);
            gr[i] = out_re;   gi[i] = out_im;
            qr[i] = out_re_q; qi[i] = out_im_q;
            start = (mode == 3 && i == 3);
        end
        start = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R7", "out_valid after stream", out_valid, 0);
        for (int i = 0; i < N; i++) begin
            chk(gr[i] == er[i], req, $sformatf("bin %0d re", i), gr[i], er[i]);
            chk(gi[i] == ei[i], req, $sformatf("bin %0d im", i), gi[i], ei[i]);
            chk(qr[i] == gr[i] && qi[i] == gi[i], "R10", $sformatf("quarter rom bin %0d", i), qr[i], gr[i]);
        end
        if (mode == 3) begin
            bad = 1'b0;
            repeat (M + 4) begin
                @(negedge clk);
                if (done || out_valid) bad = 1'b1;
            end
            chk(!bad, "R8", "no second transform", bad, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic rand_vec(int lim);
        for (int i = 0; i < N; i++) begin
            xr[i] = longint'($urandom_range(2 * lim)) - lim;
            xi[i] = longint'($urandom_range(2 * lim)) - lim;
        end
    endtask

    initial begin
        #4ms;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(17));
        repeat (4) @(negedge clk);
        chk(!done && !out_valid, "R1", "reset outputs", {done, out_valid}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2: an impulse in every position, compared to the model
        for (int p = 0; p < N; p++) begin
            for (int i = 0; i < N; i++) begin
                xr[i] = (i == p) ? 8000 : 0;
                xi[i] = (i == p) ? -3000 : 0;
            end
            run_vec("R2", 0);
        end

        // R3: constant input, closed form: bin 0 equals the constant, others zero
        for (int i = 0; i < N; i++) begin xr[i] = 4000; xi[i] = -2000; end
        run_vec("R3", 0);
        chk(gr[0] == 4000 && gi[0] == -2000, "R3", "dc bin", gr[0], 4000);
        for (int i = 1; i < N; i++)
            chk(gr[i] == 0 && gi[i] == 0, "R3", $sformatf("dc leakage bin %0d", i), gr[i], 0);

        // R4: ramp exercises every pair spacing and twiddle
        for (int i = 0; i < N; i++) begin xr[i] = i * 1500 - 5000; xi[i] = 3000 - i * 700; end
        run_vec("R4", 0);

        rand_vec(12000);
        run_vec("R3", 1);
        rand_vec(12000);
        run_vec("R9", 2);
        rand_vec(15000);
        run_vec("R3", 3);
        rand_vec(16000);
        run_vec("R3", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule